// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block closes the feedback side of a frequency synthesizer loop. A fast oscillator drives a prescaler whose ratio can be switched between P and P+1. The block models that prescaler digitally: it counts single-cycle `vco_tick` enables, one per oscillator cycle. It steers the prescaler's modulus and counts the prescaler's output with a main counter N and a swallow counter A. Once every P×N+A oscillator cycles it emits one feedback pulse. For the first A prescaler cycles of an output period the prescaler divides by P+1, and for the remaining N−A cycles it divides by P. The base modulus P is 64 or 128. The swallow count must be smaller than N.

A second, independent counter divides a reference tick stream by R and produces the reference pulse that the phase comparator sees next to the feedback pulse. Settings arrive as 18-bit words on a single-cycle write port. Each write is held in a shadow register until the running output period ends, so a period in progress is never shortened or stretched. A main or reference ratio below 3 is replaced by 3, and the error output is raised.

Top module: `swallow_div`

## Requirements
- R1: After reset all outputs are low, and the block runs with N=3, A=0, P=128 and R=3, so the first feedback period is 384 ticks.
- R2: `fb_pulse` is high for exactly one clock, in the clock after the `vco_tick` that completes P×N+A counted ticks since the previous feedback pulse.
- R3: The modulus bit is bit 14 of a reference word. A value of 1 selects P=64 (prescaler ratio 64/65), and 0 selects P=128 (ratio 128/129).
- R4: `mod_ctl` is high for the first A prescaler cycles of every output period, which is exactly A×(P+1) ticks, and it changes only in the clock after a `vco_tick`.
- R5: A write with `wr_sel`=0 is a divider word with N=`wr_data[10:0]` and A=`wr_data[17:11]`. A write with `wr_sel`=1 is a reference word with R=`wr_data[13:0]` and the modulus bit in `wr_data[14]`.
- R6: New N, A and modulus values take effect only at the next feedback boundary, and a new R only at the next reference boundary. The period running during the write keeps its old length.
- R7: A written N or R below 3 is used as 3. `cfg_err` is high exactly when the most recent write carried such a value, and it updates in the clock after that write.
- R8: `ref_pulse` is high for one clock, in the clock after the `ref_tick` that completes R counted reference ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one setting word |
| wr_sel | input | 1 | 0 = divider word, 1 = reference word |
| wr_data | input | 18 | Setting word |
| vco_tick | input | 1 | One pulse per oscillator cycle |
| ref_tick | input | 1 | One pulse per reference cycle |
| mod_ctl | output | 1 | Prescaler modulus control, 1 = divide by P+1 |
| fb_pulse | output | 1 | Feedback pulse, one per P×N+A ticks |
| ref_pulse | output | 1 | Reference pulse, one per R reference ticks |
| cfg_err | output | 1 | Last write carried N or R below 3 |

## Verification
Each output has a fixed latency:
- `fb_pulse` and `ref_pulse` are due one clock after the tick that completes their count.
- `cfg_err` is due one clock after the write.
- A new setting shows only in the period after the next boundary.

The bench drives inputs at falling edges and samples outputs at the following falling edge, so each result is read exactly one register stage after its cause. Periods are measured as counts of ticks between two observed pulses. After every write the bench discards one period before it compares the measured length with P×N+A. While measuring, it also counts how many ticks were consumed with `mod_ctl` high.

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int NW     = 11,
  parameter int AW     = 7,
  parameter int RW     = 14,
  parameter int DW     = 18,
  parameter int NMIN   = 3,
  parameter int PSMALL = 64,
  parameter int PLARGE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          vco_tick,
  input  logic          ref_tick,
  output logic          mod_ctl,
  output logic          fb_pulse,
  output logic          ref_pulse,
  output logic          cfg_err
);
  localparam int PCW = $clog2(PLARGE + 1);
  localparam logic [PCW-1:0] LAST_S = PCW'(PSMALL - 1);
  localparam logic [PCW-1:0] LAST_L = PCW'(PLARGE - 1);
  localparam logic [NW-1:0]  N_DEF  = NW'(NMIN);
  localparam logic [RW-1:0]  R_DEF  = RW'(NMIN);

  logic [NW-1:0]  n_lat, n_cnt;
  logic [AW-1:0]  a_lat, a_cnt;
  logic [RW-1:0]  r_lat, r_cnt;
  logic           p64_lat, p64_act;
  logic [PCW-1:0] pc;

  wire [NW-1:0] n_in   = wr_data[NW-1:0];
  wire [AW-1:0] a_in   = wr_data[NW+AW-1:NW];
  wire [RW-1:0] r_in   = wr_data[RW-1:0];
  wire          p64_in = wr_data[RW];
  wire          n_bad  = n_in < N_DEF;
  wire          r_bad  = r_in < R_DEF;

  assign mod_ctl = (a_cnt != '0);

  wire [PCW-1:0] pc_last = (p64_act ? LAST_S : LAST_L) + PCW'(mod_ctl);
  wire pre_end = vco_tick && (pc == pc_last);
  wire out_end = pre_end && (n_cnt == NW'(1));
  wire ref_end = ref_tick && (r_cnt == RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_lat   <= N_DEF;
      a_lat   <= '0;
      r_lat   <= R_DEF;
      p64_lat <= 1'b0;
      cfg_err <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel) begin
        r_lat   <= r_bad ? R_DEF : r_in;
        p64_lat <= p64_in;
        cfg_err <= r_bad;
      end else begin
        n_lat   <= n_bad ? N_DEF : n_in;
        a_lat   <= a_in;
        cfg_err <= n_bad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= '0;
      n_cnt    <= N_DEF;
      a_cnt    <= '0;
      p64_act  <= 1'b0;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= out_end;
      if (vco_tick) pc <= pre_end ? '0 : pc + PCW'(1);
      if (out_end) begin
        n_cnt   <= n_lat;
        a_cnt   <= a_lat;
        p64_act <= p64_lat;
      end else if (pre_end) begin
        n_cnt <= n_cnt - NW'(1);
        if (mod_ctl) a_cnt <= a_cnt - AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_cnt     <= R_DEF;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= ref_end;
      if (ref_end) r_cnt <= r_lat;
      else if (ref_tick) r_cnt <= r_cnt - RW'(1);
    end
  end
endmodule

module swallow_div_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic vco_tick,
  input logic ref_tick,
  input logic mod_ctl,
  input logic fb_pulse,
  input logic ref_pulse,
  input logic cfg_err
);
  p_fb_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> $past(vco_tick));
  p_fb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);
  p_mod_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_tick |=> $stable(mod_ctl));
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_err));
  p_ref_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_tick));
endmodule

bind swallow_div swallow_div_chk u_chk (.*);

// File: tb/tb_swallow_div.sv
`timescale 1ns/1ps
module tb_swallow_div;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [17:0] wr_data = '0;
  logic vco_tick = 1'b0, ref_tick = 1'b0;
  logic mod_ctl, fb_pulse, ref_pulse, cfg_err;
  int n_run = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  swallow_div dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .vco_tick(vco_tick), .ref_tick(ref_tick),
    .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .cfg_err(cfg_err));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected under 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  function automatic int exp_fb(bit p64, int n, int a);
    int nn = (n < 3) ? 3 : n;
    return (p64 ? 64 : 128) * nn + a;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [17:0] d, output bit err);
    @(negedge clk);
    vco_tick = 0; ref_tick = 0;
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    err = cfg_err;
  endtask

  task automatic fb_period(int inj_at, bit inj_sel, logic [17:0] inj_d,
                           output int ticks, output int hi);
    ticks = 0; hi = 0;
    for (int k = 0; ; k++) begin
      @(negedge clk);
      wr_en = 0;
      if (fb_pulse) begin vco_tick = 0; break; end
      if (k == inj_at) begin
        vco_tick = 0; wr_en = 1; wr_sel = inj_sel; wr_data = inj_d;
      end else begin
        vco_tick = ($urandom_range(0, 3) != 0);
        if (vco_tick) begin ticks++; if (mod_ctl) hi++; end
      end
    end
  endtask

  task automatic ref_period(output int ticks);
    ticks = 0;
    forever begin
      @(negedge clk);
      if (ref_pulse) begin ref_tick = 0; break; end
      ref_tick = ($urandom_range(0, 1) != 0);
      if (ref_tick) ticks++;
    end
  endtask

  task automatic cfg_check(bit p64, int n, int a, string tag);
    bit e; int t, h;
    wr(1'b1, {3'b0, p64, 14'd3}, e);
    wr(1'b0, {7'(a), 11'(n)}, e);
    fb_period(-1, 0, '0, t, h);
    fb_period(-1, 0, '0, t, h);
    check({tag, " R2 R3 period"}, t, exp_fb(p64, n, a));
    check({tag, " R4 mod_ctl ticks"}, h, a * ((p64 ? 64 : 128) + 1));
  endtask

  initial begin
    bit e; int t, h;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 fb_pulse reset", fb_pulse, 0);
    check("R1 ref_pulse reset", ref_pulse, 0);
    check("R1 mod_ctl reset", mod_ctl, 0);
    check("R1 cfg_err reset", cfg_err, 0);
    fb_period(-1, 0, '0, t, h);
    check("R1 R2 default period", t, 384);
    ref_period(t);
    check("R1 R8 default ref period", t, 3);

    cfg_check(1, 3, 2, "directed p64 N3 A2");
    cfg_check(1, 3, 0, "directed p64 N3 A0");
    cfg_check(0, 4, 3, "directed p128 N4 A3");
    for (int i = 0; i < 6; i++) begin
      int n = $urandom_range(3, 20);
      cfg_check(1'($urandom_range(0, 1)), n, $urandom_range(0, n - 1), "random");
    end
    cfg_check(1, 40, 39, "directed p64 N40 A39");

    wr(1'b0, {7'd0, 11'd1}, e);
    check("R7 R5 cfg_err on N=1", e, 1);
    fb_period(-1, 0, '0, t, h);
    fb_period(-1, 0, '0, t, h);
    check("R7 N clamp period", t, exp_fb(1, 3, 0));
    wr(1'b0, {7'd1, 11'd4}, e);
    check("R7 cfg_err cleared", e, 0);
    fb_period(-1, 0, '0, t, h);
    fb_period(-1, 0, '0, t, h);
    check("R6 setup period", t, 257);
    fb_period(50, 1'b0, {7'd3, 11'd5}, t, h);
    check("R6 period during write unchanged", t, 257);
    fb_period(-1, 0, '0, t, h);
    check("R6 next period new value", t, 323);
    check("R6 R4 next period mod ticks", h, 3 * 65);

    wr(1'b1, {3'b0, 1'b1, 14'd5}, e);
    ref_period(t);
    ref_period(t);
    check("R8 ref period R=5", t, 5);
    wr(1'b1, {3'b0, 1'b1, 14'd0}, e);
    check("R7 cfg_err on R=0", e, 1);
    ref_period(t);
    ref_period(t);
    check("R7 R clamp period", t, 3);
    wr(1'b1, {3'b0, 1'b1, 14'd200}, e);
    check("R7 cfg_err cleared by R=200", e, 0);
    ref_period(t);
    ref_period(t);
    check("R8 ref period R=200", t, 200);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule